// File: doc/BRIEF.md
# Predicated Execute Stage with Condition Flags

This block is the execute stage of a register-register processor in which every instruction is predicated. A compare instruction subtracts its operands and stores the outcome in four condition flags: negative, zero, carry and overflow. Each instruction carries a 4-bit condition code. The instruction commits only when that code holds against the flags left by the most recent committed compare.

The second operand always passes through a left shifter before the arithmetic. The shift amount comes from the instruction, so `dst = a + (b << n)` takes a single operation; for example, n = 4 scales `b` by 16. Add and subtract produce a register write. Compare updates only the flags. A conditional branch raises a taken flag. Outputs are registered, so they appear one clock after the instruction is presented. The register file and instruction fetch sit outside this block.

Top module: `pred_exec_stage`

## Requirements
- R1: An add (op 0) whose condition holds drives `result = src_a + (src_b << shamt)` (modulo 2^32) with `wr_en` high and `wr_dst = dst`, one clock after it is presented.
- R2: A subtract (op 1) whose condition holds drives `result = src_a - (src_b << shamt)` with `wr_en` high and `wr_dst = dst`.
- R3: A compare (op 2) whose condition holds sets the flags from `src_a - (src_b << shamt)`. N is bit 31 of the difference, Z is set when the difference is zero, C is set when src_a >= shifted src_b unsigned, and V is set on signed overflow. A compare never raises `wr_en`.
- R4: Condition code 0 (EQ) passes when Z = 1, and code 1 (NE) passes when Z = 0.
- R5: Code 12 (GT) passes when Z = 0 and N = V. Code 13 (LE) passes when Z = 1 or N != V. After a compare, these codes give signed greater-than and signed less-or-equal.
- R6: Code 10 (GE) passes when N = V, and code 11 (LT) passes when N != V.
- R7: An instruction whose condition fails raises neither `wr_en` nor `br_taken`, and a failed compare leaves the flags unchanged.
- R8: A branch (op 3) raises `br_taken` exactly when its condition holds and never raises `wr_en`.
- R9: Code 14 (AL) always passes and code 15 (NV) never passes.
- R10: Outputs are registered. In a cycle with `in_valid` low, `wr_en` and `br_taken` are low on the next clock and the flags are unchanged.
- R11: After reset, `wr_en`, `br_taken`, `result` and `wr_dst` are zero and all four flags are clear. With clear flags, NE, GE and GT pass, and EQ, LT and LE fail.
- R12: The remaining codes are 2 (C = 1), 3 (C = 0), 4 (N = 1), 5 (N = 0), 6 (V = 1), 7 (V = 0), 8 (C = 1 and Z = 0) and 9 (C = 0 or Z = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is present this cycle |
| op | input | 2 | 0 add, 1 subtract, 2 compare, 3 branch |
| cond | input | 4 | Condition code |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand, shifted before use |
| shamt | input | 5 | Left shift amount for the second operand |
| dst | input | 4 | Destination register index |
| result | output | 32 | Arithmetic result |
| wr_en | output | 1 | Commit the result to the register file |
| wr_dst | output | 4 | Destination index of the committed result |
| br_taken | output | 1 | Conditional branch is taken |

## Verification
The assertions assume that `in_valid` is low during reset and that every field is at a known value whenever `in_valid` is high. The bench meets both assumptions: it holds `in_valid` low until reset is released, and from then on it drives every field at each falling edge. Random stimulus makes one operand pair in four equal and leaves the sign bits free, so that all sixteen condition codes are reached with the zero, signed-overflow and unsigned-carry cases.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0, OP_SUB = 2'd1, OP_CMP = 2'd2, OP_BR = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0, CC_NE = 4'd1, CC_HS = 4'd2, CC_LO = 4'd3,
    CC_MI = 4'd4, CC_PL = 4'd5, CC_VS = 4'd6, CC_VC = 4'd7,
    CC_HI = 4'd8, CC_LS = 4'd9, CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Condition evaluation against the stored flags (R4, R5, R6, R9, R12)
  function automatic logic cond_holds(input cond_e cc, input flags_t f);
    logic ok;
    case (cc)
      CC_EQ: ok = f.z;
      CC_NE: ok = !f.z;
      CC_HS: ok = f.c;
      CC_LO: ok = !f.c;
      CC_MI: ok = f.n;
      CC_PL: ok = !f.n;
      CC_VS: ok = f.v;
      CC_VC: ok = !f.v;
      CC_HI: ok = f.c && !f.z;
      CC_LS: ok = !f.c || f.z;
      CC_GE: ok = (f.n == f.v);
      CC_LT: ok = (f.n != f.v);
      CC_GT: ok = !f.z && (f.n == f.v);
      CC_LE: ok = f.z || (f.n != f.v);
      CC_AL: ok = 1'b1;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/pe_shifter.sv
module pe_shifter #(
  parameter int DW  = 32,
  parameter int SHW = $clog2(DW)
) (
  input  logic [DW-1:0]  opnd,
  input  logic [SHW-1:0] amt,
  output logic [DW-1:0]  shifted
);
  // Logarithmic barrel: one stage per shift-amount bit
  logic [DW-1:0] stage [SHW+1];
  assign stage[0] = opnd;
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    assign stage[k+1] = amt[k] ? (stage[k] << (1 << k)) : stage[k];
  end
  assign shifted = stage[SHW];
endmodule

// File: rtl/pe_alu.sv
module pe_alu
  import pe_pkg::*;
#(
  parameter int DW = 32
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum,
  output flags_t        cmp_flags
);
  function automatic logic [DW:0] wide_sub(input logic [DW-1:0] x, input logic [DW-1:0] y);
    return {1'b0, x} + {1'b0, ~y} + {{DW{1'b0}}, 1'b1};
  endfunction

  function automatic flags_t flags_from(input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic [DW:0] w;
    flags_t f;
    w   = wide_sub(x, y);
    f.n = w[DW-1];
    f.z = (w[DW-1:0] == '0);
    f.c = w[DW];
    f.v = (x[DW-1] != y[DW-1]) && (w[DW-1] != x[DW-1]);
    return f;
  endfunction

  logic [DW:0] diff;
  assign diff      = wide_sub(a, b);
  assign sum       = (op == OP_ADD) ? (a + b) : diff[DW-1:0];
  assign cmp_flags = flags_from(a, b);
endmodule

// File: rtl/pred_exec_stage.sv
module pred_exec_stage
  import pe_pkg::*;
#(
  parameter int DW  = 32,
  parameter int RW  = 4,
  parameter int SHW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [1:0]     op,
  input  logic [3:0]     cond,
  input  logic [DW-1:0]  src_a,
  input  logic [DW-1:0]  src_b,
  input  logic [SHW-1:0] shamt,
  input  logic [RW-1:0]  dst,
  output logic [DW-1:0]  result,
  output logic           wr_en,
  output logic [RW-1:0]  wr_dst,
  output logic           br_taken
);
  op_e           op_q;
  flags_t        flags_q;
  flags_t        flags_nxt;
  logic [DW-1:0] b_shifted;
  logic [DW-1:0] alu_out;

  // Named internal events for the checker
  logic cond_ok;
  logic flag_upd;
  logic do_write;
  logic do_branch;

  assign op_q = op_e'(op);

  pe_shifter #(.DW(DW), .SHW(SHW)) u_shift (
    .opnd(src_b), .amt(shamt), .shifted(b_shifted)
  );

  pe_alu #(.DW(DW)) u_alu (
    .op(op_q), .a(src_a), .b(b_shifted), .sum(alu_out), .cmp_flags(flags_nxt)
  );

  assign cond_ok   = cond_holds(cond_e'(cond), flags_q);
  assign flag_upd  = in_valid && cond_ok && (op_q == OP_CMP);
  assign do_write  = in_valid && cond_ok && ((op_q == OP_ADD) || (op_q == OP_SUB));
  assign do_branch = in_valid && cond_ok && (op_q == OP_BR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q  <= '0;
      result   <= '0;
      wr_en    <= 1'b0;
      wr_dst   <= '0;
      br_taken <= 1'b0;
    end else begin
      wr_en    <= do_write;
      br_taken <= do_branch;
      if (flag_upd) flags_q <= flags_nxt;
      if (in_valid) begin
        result <= alu_out;
        wr_dst <= dst;
      end
    end
  end
endmodule

// File: rtl/pe_checker.sv
module pe_checker
  import pe_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] op,
  input logic [3:0] cond,
  input logic       wr_en,
  input logic       br_taken,
  input logic       flag_upd,
  input flags_t     flags_q
);
  // R3: a compare never commits a register write
  p_cmp_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd2) |=> !wr_en);

  // R7: flags move only on a committed compare
  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_upd |=> $stable(flags_q));

  // R8: a branch never writes
  p_branch_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd3) |=> !wr_en);

  // R9: the never code suppresses everything
  p_never_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == 4'd15) |=> (!wr_en && !br_taken));

  // R9: the always code commits an add
  p_always_adds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == 4'd14 && op == 2'd0) |=> wr_en);

  // R10: an idle cycle produces no commit and no branch
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!wr_en && !br_taken && $stable(flags_q)));

  // R8: write and branch never coincide
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && br_taken));
endmodule

bind pred_exec_stage pe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .cond(cond),
  .wr_en(wr_en), .br_taken(br_taken), .flag_upd(flag_upd), .flags_q(flags_q)
);

// File: tb/pred_exec_stage_test.sv
module pred_exec_stage_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = '0;
  logic [3:0]  cond = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [4:0]  shamt = '0;
  logic [3:0]  dst = '0;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  wr_dst;
  logic        br_taken;

  int n_checks = 0;
  int n_fail = 0;
  logic [3:0] mflags = 4'b0000;  // {n,z,c,v} model

  always #4 clk = ~clk;

  pred_exec_stage uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .cond(cond),
    .src_a(src_a), .src_b(src_b), .shamt(shamt), .dst(dst),
    .result(result), .wr_en(wr_en), .wr_dst(wr_dst), .br_taken(br_taken)
  );

  function automatic logic [3:0] model_flags(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] d;
    logic n, slt;
    d   = a - b;
    n   = d[31];
    slt = ($signed(a) < $signed(b));
    return {n, (a == b), (a >= b), n ^ slt};
  endfunction

  function automatic logic model_pass(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0:  return z;
      4'd1:  return ~z;
      4'd2:  return cy;
      4'd3:  return ~cy;
      4'd4:  return n;
      4'd5:  return ~n;
      4'd6:  return v;
      4'd7:  return ~v;
      4'd8:  return cy & ~z;
      4'd9:  return ~(cy & ~z);
      4'd10: return ~(n ^ v);
      4'd11: return n ^ v;
      4'd12: return ~z & ~(n ^ v);
      4'd13: return ~(~z & ~(n ^ v));
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] o, input logic [3:0] c, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] s, input logic [3:0] d,
                       input string req);
    logic pass, exp_we, exp_tk;
    logic [31:0] bs, exp_res;
    bs      = b << s;
    pass    = model_pass(c, mflags);
    exp_we  = pass && (o == 2'd0 || o == 2'd1);
    exp_tk  = pass && (o == 2'd3);
    exp_res = (o == 2'd0) ? a + bs : a - bs;
    @(negedge clk);
    in_valid = 1'b1; op = o; cond = c; src_a = a; src_b = b; shamt = s; dst = d;
    @(posedge clk);
    #1;
    check(wr_en == exp_we, req, "wr_en", {31'b0, wr_en}, {31'b0, exp_we});
    check(br_taken == exp_tk, req, "br_taken", {31'b0, br_taken}, {31'b0, exp_tk});
    if (exp_we) begin
      check(result == exp_res, req, "result", result, exp_res);
      check(wr_dst == d, req, "wr_dst", {28'b0, wr_dst}, {28'b0, d});
    end
    if (o == 2'd2 && pass) mflags = model_flags(a, bs);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    op = 2'd0; cond = 4'd14;
    @(posedge clk);
    #1;
    check(!wr_en && !br_taken, "R10", "idle outputs", {30'b0, wr_en, br_taken}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    check(result == 32'd0 && wr_en == 1'b0 && wr_dst == 4'd0 && br_taken == 1'b0,
          "R11", "reset outputs", {wr_en, br_taken, wr_dst, result[25:0]}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: cleared flags -> NE/GE/GT pass, EQ/LT/LE fail (branch probes)
    issue(2'd3, 4'd1, 0, 0, 0, 0, "R11");
    issue(2'd3, 4'd0, 0, 0, 0, 0, "R11");
    issue(2'd3, 4'd12, 0, 0, 0, 0, "R11");
    issue(2'd3, 4'd13, 0, 0, 0, 0, "R11");
    // R1: add with shift by 4: 3 + 5*16 = 83
    issue(2'd0, 4'd14, 32'd3, 32'd5, 5'd4, 4'd7, "R1");
    check(result == 32'd83, "R1", "shift add", result, 32'd83);
    // R5: 7 > 3 -> SUB GT writes, SUB LE suppressed
    issue(2'd2, 4'd14, 32'd7, 32'd3, 0, 0, "R3");
    issue(2'd1, 4'd12, 32'd7, 32'd3, 0, 4'd2, "R5");
    issue(2'd1, 4'd13, 32'd3, 32'd7, 0, 4'd3, "R5");
    // R6: signed -1 < 1
    issue(2'd2, 4'd14, 32'hFFFF_FFFF, 32'd1, 0, 0, "R3");
    issue(2'd0, 4'd11, 32'd1, 32'd1, 0, 4'd4, "R6");
    issue(2'd0, 4'd10, 32'd1, 32'd1, 0, 4'd4, "R6");
    // R12: unsigned: 0xFFFFFFFF higher than 1
    issue(2'd3, 4'd8, 0, 0, 0, 0, "R12");
    issue(2'd3, 4'd6, 0, 0, 0, 0, "R12");
    // R4: equal compare, NE branch not taken, EQ taken
    issue(2'd2, 4'd14, 32'd9, 32'd9, 0, 0, "R3");
    issue(2'd3, 4'd1, 0, 0, 0, 0, "R4");
    issue(2'd3, 4'd0, 0, 0, 0, 0, "R4");
    // R7: suppressed compare (NV) leaves flags: EQ still taken
    issue(2'd2, 4'd15, 32'd1, 32'd2, 0, 0, "R7");
    issue(2'd3, 4'd0, 0, 0, 0, 0, "R7");
    // R5: signed overflow case 0x80000000 vs 1 -> LE passes
    issue(2'd2, 4'd14, 32'h8000_0000, 32'd1, 0, 0, "R3");
    issue(2'd1, 4'd13, 32'd10, 32'd4, 5'd1, 4'd9, "R5");
    issue(2'd3, 4'd6, 0, 0, 0, 0, "R12");
    // R9: NV add suppressed, R10 idle
    issue(2'd0, 4'd15, 32'd1, 32'd1, 0, 4'd1, "R9");
    idle();
    issue(2'd3, 4'd6, 0, 0, 0, 0, "R10");
    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  ro;
      logic [31:0] ra, rb;
      logic [4:0]  rs;
      ro = 2'($urandom % 4);
      rb = $urandom;
      ra = ($urandom % 4 == 0) ? rb : $urandom;
      rs = ($urandom % 3 == 0) ? 5'($urandom % 32) : 5'd0;
      if (ra == rb) rs = 5'd0;
      case (ro)
        2'd0: issue(ro, 4'($urandom % 16), ra, rb, rs, 4'($urandom % 16), "R1");
        2'd1: issue(ro, 4'($urandom % 16), ra, rb, rs, 4'($urandom % 16), "R2");
        2'd2: issue(ro, 4'($urandom % 16), ra, rb, rs, 4'($urandom % 16), "R3");
        default: issue(ro, 4'($urandom % 16), ra, rb, rs, 4'($urandom % 16), "R8");
      endcase
      if (i % 37 == 0) idle();
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule